// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page translations so that a memory access can find its physical page number without walking the page tables. The cache is split into sets; the topmost bits of the linear address choose the set, and every set holds eight entries. A stored entry keeps a virtual page number, five attribute bits and a result word. Each entry also carries a page size, which decides whether it covers 4 KB or 4 MB of address space. A lookup gives its address and requested attributes together with a per-lookup ignore mask. The result is a hit flag, the matching way and the stored word, all in the same cycle.

Inside each set the entries are ranked by how recently they were used. A hit moves the entry to the front of that ranking. A fill writes the lowest-numbered free entry if one exists, and otherwise overwrites the entry used least recently; the new entry then becomes the most recent. A single invalidate input empties the whole cache in one cycle. The page table walk that produces fill data is outside this block.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, and `lk_hit_o` stays 0 on every lookup until a fill has been accepted.
- R2: The set is `addr[31:30]` (with four sets) for both lookup and fill. A fill changes only the set it addresses.
- R3: A 4 KB entry hits when `addr[31:12]` equals its stored page and every attribute bit not ignored matches. On a hit, `lk_way_o` and `lk_data_o` belong to that entry, in the same cycle as the lookup.
- R4: Attribute bit positions are bit0 writable, bit1 user, bit2 dirty, bit3 accessed and bit4 page size. A set bit in `lk_ign_i` leaves that attribute out of the compare; a clear bit makes a mismatch a miss.
- R5: A fill with `fl_attr_i[4]`=1 makes a 4 MB entry that compares only `addr[31:22]`. A lookup with `large_en_i`=1 first compares with size bit 1 and then with size bit 0. With `large_en_i`=0 only the size-0 compare is made.
- R6: When the size-1 compare hits, its result is returned even if a size-0 entry also matches. Within one compare the lowest matching way wins.
- R7: A fill writes the lowest-numbered invalid way of its set.
- R8: When the set is full, a fill replaces the least recently used way. Both a lookup hit and a fill make the entry the most recently used.
- R9: When a lookup and a fill address the same set in one cycle, the fill updates the recency ranking and the lookup hit does not.
- R10: `inv_all_i` empties every set from the next cycle on, takes priority over a fill in the same cycle, and resets the recency ranking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Lookup linear address |
| lk_attr_i | input | 4 | Requested writable, user, dirty, accessed bits |
| lk_ign_i | input | 5 | Attribute bits left out of the compare |
| large_en_i | input | 1 | Enables the 4 MB compare |
| lk_hit_o | output | 1 | Lookup hit |
| lk_way_o | output | 3 | Way that hit |
| lk_data_o | output | 20 | Stored word of the entry that hit |
| fl_valid_i | input | 1 | Fill request |
| fl_addr_i | input | 32 | Fill linear address |
| fl_attr_i | input | 5 | Attributes of the new entry, size in bit 4 |
| fl_data_i | input | 20 | Word stored with the new entry |
| inv_all_i | input | 1 | Invalidate every entry |

## Verification
Lookup results are combinational, so the bench drives the inputs on the falling edge and compares hit, way and word one time unit later, before the next rising edge. Fills, invalidations and recency changes become visible to lookups from the following cycle. The bench's reference model therefore applies a cycle's updates only after that cycle's outputs have been compared. Eviction order, including the case where the fill wins over the lookup in R9, is checked by which entry goes missing on later lookups.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  localparam int ATTR_W = 5;
  localparam int A_WR   = 0;
  localparam int A_USR  = 1;
  localparam int A_DRT  = 2;
  localparam int A_ACC  = 3;
  localparam int A_SZ   = 4;
  typedef logic [ATTR_W-1:0] attr_t;
endpackage

// File: rtl/xlat_cache_lru.sv
module xlat_cache_lru #(
  parameter int WAYS = 8,
  localparam int IW  = $clog2(WAYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inv_i,
  input  logic          prom_i,
  input  logic [IW-1:0] prom_way_i,
  output logic [IW-1:0] oldest_o
);
  logic [IW-1:0] age_q [WAYS];
  logic [IW-1:0] prom_age;

  assign prom_age = age_q[prom_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= IW'(w);
    end else if (inv_i) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= IW'(w);
    end else if (prom_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (IW'(w) == prom_way_i)    age_q[w] <= '0;
        else if (age_q[w] < prom_age) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[w] == IW'(WAYS-1)) oldest_o = IW'(w);
  end
endmodule

// File: rtl/xlat_cache_set.sv
module xlat_cache_set
  import xlat_cache_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int LVPN_W = 10,
  parameter int DW     = 20,
  localparam int IW    = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inv_i,
  input  logic             lk_en_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [3:0]       lk_attr_i,
  input  attr_t            lk_ign_i,
  input  logic             large_en_i,
  input  logic             fl_en_i,
  input  logic [VPN_W-1:0] fl_vpn_i,
  input  attr_t            fl_attr_i,
  input  logic [DW-1:0]    fl_data_i,
  output logic             hit_o,
  output logic [IW-1:0]    way_o,
  output logic [DW-1:0]    data_o
);
  localparam logic [VPN_W-1:0] BIG_MASK = {{LVPN_W{1'b1}}, {(VPN_W-LVPN_W){1'b0}}};

  logic [WAYS-1:0]  vld_q;
  logic [VPN_W-1:0] vpn_q  [WAYS];
  attr_t            attr_q [WAYS];
  logic [DW-1:0]    data_q [WAYS];

  logic [WAYS-1:0] m_big, m_sml;
  logic            hit_big;
  logic [IW-1:0]   oldest, victim;
  logic            prom;
  logic [IW-1:0]   prom_way;

  function automatic logic [IW-1:0] lowest(input logic [WAYS-1:0] v);
    lowest = '0;
    for (int i = WAYS-1; i >= 0; i--) if (v[i]) lowest = IW'(i);
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [VPN_W-1:0] amask;
    logic             addr_ok;
    assign amask   = attr_q[w][A_SZ] ? BIG_MASK : '1;
    assign addr_ok = ((vpn_q[w] ^ lk_vpn_i) & amask) == '0;
    assign m_big[w] = vld_q[w] && addr_ok &&
                      (((attr_q[w] ^ {1'b1, lk_attr_i}) & ~lk_ign_i) == '0);
    assign m_sml[w] = vld_q[w] && addr_ok &&
                      (((attr_q[w] ^ {1'b0, lk_attr_i}) & ~lk_ign_i) == '0);
  end

  // size-1 compare has precedence when large pages are on
  assign hit_big = large_en_i && (|m_big);
  assign hit_o   = hit_big || (|m_sml);
  assign way_o   = hit_big ? lowest(m_big) : lowest(m_sml);
  assign data_o  = data_q[way_o];

  assign victim   = (~vld_q != '0) ? lowest(~vld_q) : oldest;
  assign prom     = !inv_i && (fl_en_i || (lk_en_i && hit_o));
  assign prom_way = fl_en_i ? victim : way_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (inv_i)   vld_q <= '0;
    else if (fl_en_i) vld_q[victim] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fl_en_i && !inv_i) begin
      vpn_q[victim]  <= fl_vpn_i;
      attr_q[victim] <= fl_attr_i;
      data_q[victim] <= fl_data_i;
    end
  end

  xlat_cache_lru #(.WAYS(WAYS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inv_i      (inv_i),
    .prom_i     (prom),
    .prom_way_i (prom_way),
    .oldest_o   (oldest)
  );
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PG_W   = 12,
  parameter int BIG_W  = 22,
  parameter int DW     = 20,
  parameter int SETS   = 4,
  parameter int WAYS   = 8,
  localparam int IW    = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int VPN_W = AW - PG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_addr_i,
  input  logic [3:0]    lk_attr_i,
  input  logic [4:0]    lk_ign_i,
  input  logic          large_en_i,
  output logic          lk_hit_o,
  output logic [IW-1:0] lk_way_o,
  output logic [DW-1:0] lk_data_o,
  input  logic          fl_valid_i,
  input  logic [AW-1:0] fl_addr_i,
  input  logic [4:0]    fl_attr_i,
  input  logic [DW-1:0] fl_data_i,
  input  logic          inv_all_i
);
  logic [SET_W-1:0] lk_set, fl_set;
  logic [SETS-1:0]  set_hit;
  logic [IW-1:0]    set_way  [SETS];
  logic [DW-1:0]    set_data [SETS];

  assign lk_set = lk_addr_i[AW-1 -: SET_W];
  assign fl_set = fl_addr_i[AW-1 -: SET_W];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    xlat_cache_set #(
      .WAYS(WAYS), .VPN_W(VPN_W), .LVPN_W(AW-BIG_W), .DW(DW)
    ) u_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inv_i      (inv_all_i),
      .lk_en_i    (lk_valid_i && (lk_set == SET_W'(s))),
      .lk_vpn_i   (lk_addr_i[AW-1:PG_W]),
      .lk_attr_i  (lk_attr_i),
      .lk_ign_i   (lk_ign_i),
      .large_en_i (large_en_i),
      .fl_en_i    (fl_valid_i && (fl_set == SET_W'(s))),
      .fl_vpn_i   (fl_addr_i[AW-1:PG_W]),
      .fl_attr_i  (fl_attr_i),
      .fl_data_i  (fl_data_i),
      .hit_o      (set_hit[s]),
      .way_o      (set_way[s]),
      .data_o     (set_data[s])
    );
  end

  assign lk_hit_o  = lk_valid_i && set_hit[lk_set];
  assign lk_way_o  = set_way[lk_set];
  assign lk_data_o = set_data[lk_set];
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int AW    = 32,
  parameter int PG_W  = 12,
  parameter int DW    = 20,
  parameter int SET_W = 2,
  parameter int IW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lk_valid_i,
  input logic [AW-1:0] lk_addr_i,
  input logic [3:0]    lk_attr_i,
  input logic [4:0]    lk_ign_i,
  input logic          large_en_i,
  input logic          lk_hit_o,
  input logic [IW-1:0] lk_way_o,
  input logic [DW-1:0] lk_data_o,
  input logic          fl_valid_i,
  input logic [AW-1:0] fl_addr_i,
  input logic [4:0]    fl_attr_i,
  input logic          inv_all_i
);
  logic filled_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         filled_q <= 1'b0;
    else if (inv_all_i)  filled_q <= 1'b0;
    else if (fl_valid_i) filled_q <= 1'b1;
  end

  a_r1_miss_until_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !filled_q |-> !lk_hit_o);

  a_r10_inv_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !lk_hit_o);

  a_r3_fill_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_valid_i && !inv_all_i && !fl_attr_i[4]) |=>
      (!(lk_valid_i && lk_addr_i[AW-1:PG_W] == $past(fl_addr_i[AW-1:PG_W]) &&
         {1'b0, lk_attr_i} == $past(fl_attr_i)) || lk_hit_o));

  a_r2_other_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !inv_all_i &&
     (!fl_valid_i || fl_addr_i[AW-1 -: SET_W] != lk_addr_i[AW-1 -: SET_W])) |=>
      (!(lk_valid_i && $stable(lk_addr_i) && $stable(lk_attr_i) &&
         $stable(lk_ign_i) && $stable(large_en_i)) ||
       (lk_hit_o && $stable(lk_way_o) && $stable(lk_data_o))));
endmodule

bind xlat_cache xlat_cache_chk #(
  .AW(AW), .PG_W(PG_W), .DW(DW), .SET_W(SET_W), .IW(IW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lk_valid_i (lk_valid_i),
  .lk_addr_i  (lk_addr_i),
  .lk_attr_i  (lk_attr_i),
  .lk_ign_i   (lk_ign_i),
  .large_en_i (large_en_i),
  .lk_hit_o   (lk_hit_o),
  .lk_way_o   (lk_way_o),
  .lk_data_o  (lk_data_o),
  .fl_valid_i (fl_valid_i),
  .fl_addr_i  (fl_addr_i),
  .fl_attr_i  (fl_attr_i),
  .inv_all_i  (inv_all_i)
);

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int SETS = 4;
  localparam int WAYS = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [3:0]  lk_attr = '0;
  logic [4:0]  lk_ign = '0;
  logic        large_en = 1'b0;
  logic        lk_hit;
  logic [2:0]  lk_way;
  logic [19:0] lk_data;
  logic        fl_valid = 1'b0;
  logic [31:0] fl_addr = '0;
  logic [4:0]  fl_attr = '0;
  logic [19:0] fl_data = '0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_attr_i(lk_attr),
    .lk_ign_i(lk_ign), .large_en_i(large_en),
    .lk_hit_o(lk_hit), .lk_way_o(lk_way), .lk_data_o(lk_data),
    .fl_valid_i(fl_valid), .fl_addr_i(fl_addr), .fl_attr_i(fl_attr),
    .fl_data_i(fl_data), .inv_all_i(inv_all)
  );

  // reference model
  bit          mv   [SETS][WAYS];
  logic [19:0] mvpn [SETS][WAYS];
  logic [4:0]  mat  [SETS][WAYS];
  logic [19:0] md   [SETS][WAYS];
  int          mage [SETS][WAYS];

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mv[s][w] = 0; mage[s][w] = w; end
  endtask

  function automatic bit mt(int s, int w, logic [19:0] v, logic [4:0] at, logic [4:0] ig);
    logic [19:0] msk;
    msk = mat[s][w][4] ? 20'hFFC00 : 20'hFFFFF;
    return mv[s][w] && (((mvpn[s][w] ^ v) & msk) == 0) && (((mat[s][w] ^ at) & ~ig) == 0);
  endfunction

  task automatic m_look(input logic [31:0] a, input logic [3:0] at, input logic [4:0] ig,
                        input bit le, output bit h, output int wy);
    int s;
    s = int'(a[31:30]);
    h = 0; wy = 0;
    if (le)
      for (int w = WAYS-1; w >= 0; w--)
        if (mt(s, w, a[31:12], {1'b1, at}, ig)) begin h = 1; wy = w; end
    if (!h)
      for (int w = WAYS-1; w >= 0; w--)
        if (mt(s, w, a[31:12], {1'b0, at}, ig)) begin h = 1; wy = w; end
  endtask

  task automatic m_prom(int s, int p);
    int pa;
    pa = mage[s][p];
    for (int w = 0; w < WAYS; w++)
      if (w == p) mage[s][w] = 0;
      else if (mage[s][w] < pa) mage[s][w]++;
  endtask

  function automatic int m_victim(int s);
    for (int w = 0; w < WAYS; w++) if (!mv[s][w]) return w;
    for (int w = 0; w < WAYS; w++) if (mage[s][w] == WAYS-1) return w;
    return 0;
  endfunction

  // compare this cycle's lookup, then advance the model past the rising edge
  task automatic step(input string req);
    bit h; int wy; int ls, fs, vw;
    #1;
    m_look(lk_addr, lk_attr, lk_ign, large_en, h, wy);
    h = h && lk_valid;
    check(req, lk_hit, h);
    if (h) begin
      check(req, lk_way, wy);
      check(req, lk_data, md[int'(lk_addr[31:30])][wy]);
    end
    ls = int'(lk_addr[31:30]);
    fs = int'(fl_addr[31:30]);
    if (inv_all) m_clear();
    else begin
      if (h && !(fl_valid && fs == ls)) m_prom(ls, wy);
      if (fl_valid) begin
        vw = m_victim(fs);
        mv[fs][vw] = 1; mvpn[fs][vw] = fl_addr[31:12];
        mat[fs][vw] = fl_attr; md[fs][vw] = fl_data;
        m_prom(fs, vw);
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; fl_valid = 0; inv_all = 0; lk_ign = '0; large_en = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic [3:0] at);
    lk_valid = 1; lk_addr = a; lk_attr = at;
  endtask

  task automatic fill(input logic [31:0] a, input logic [4:0] at, input logic [19:0] d);
    fl_valid = 1; fl_addr = a; fl_attr = at; fl_data = d;
  endtask

  function automatic logic [31:0] pa(int s, int k);
    return {2'(s), 18'(k), 12'h0};
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: empty after reset
    idle(); look(pa(0, 0), 4'h0); large_en = 1; lk_ign = 5'h1f;
    #1; check("R1", lk_hit, 0);
    step("R1");

    // R7: fills take ways 0..7 in order
    for (int k = 0; k < 8; k++) begin idle(); fill(pa(0, k), 5'h00, 20'h100 + 20'(k)); step("R7"); end
    for (int k = 0; k < 8; k++) begin
      idle(); look(pa(0, k), 4'h0); #1; check("R7", lk_way, k); step("R7");
    end
    // after the lookups above way7 (last touched) is newest; re-promote way0 to set order
    for (int k = 0; k < 8; k++) begin idle(); look(pa(0, k), 4'h0); step("R8"); end
    idle(); look(pa(0, 0), 4'h0); step("R8");
    // R8: oldest is now way1
    idle(); fill(pa(0, 8), 5'h00, 20'h108); step("R8");
    idle(); look(pa(0, 1), 4'h0); #1; check("R8", lk_hit, 0); step("R8");
    idle(); look(pa(0, 8), 4'h0); #1; check("R8", lk_way, 1); step("R8");

    // R9: way2 oldest, way3 next; lookup of way3 with fill to the same set
    idle(); look(pa(0, 3), 4'h0); fill(pa(0, 9), 5'h00, 20'h109); step("R9");
    idle(); fill(pa(0, 10), 5'h00, 20'h10a); step("R9");
    idle(); look(pa(0, 3), 4'h0); #1; check("R9", lk_hit, 0); step("R9");
    idle(); look(pa(0, 10), 4'h0); #1; check("R9", lk_way, 3); step("R9");

    // R2: fill set 1, set 0 untouched
    idle(); fill(pa(1, 8), 5'h00, 20'h208); step("R2");
    idle(); look(pa(1, 8), 4'h0); #1; check("R2", lk_data, 20'h208); check("R2", lk_way, 0); step("R2");
    idle(); look(pa(0, 8), 4'h0); #1; check("R2", lk_data, 20'h108); step("R2");

    // R10: invalidate, then fill blocked by a concurrent invalidate
    idle(); inv_all = 1; step("R10");
    idle(); look(pa(0, 8), 4'h0); #1; check("R10", lk_hit, 0); step("R10");
    idle(); fill(pa(3, 5), 5'h00, 20'h305); inv_all = 1; step("R10");
    idle(); look(pa(3, 5), 4'h0); #1; check("R10", lk_hit, 0); step("R10");

    // R4/R5/R6: small and large entries over the same address in set 2
    idle(); fill(pa(2, 4), 5'h01, 20'h0000a); step("R5");
    idle(); fill(pa(2, 4), 5'h11, 20'h0000b); step("R5");
    idle(); look(pa(2, 4), 4'h1); large_en = 1; #1; check("R6", lk_data, 20'h0000b); step("R6");
    idle(); look(pa(2, 4), 4'h1); #1; check("R5", lk_data, 20'h0000a); step("R5");
    idle(); look(pa(2, 5), 4'h1); large_en = 1; #1; check("R5", lk_data, 20'h0000b); step("R5");
    idle(); look(pa(2, 5), 4'h1); #1; check("R5", lk_hit, 0); step("R5");
    idle(); look(pa(2, 4), 4'h0); large_en = 1; #1; check("R4", lk_hit, 0); step("R4");
    idle(); look(pa(2, 4), 4'h0); lk_ign = 5'h01; #1; check("R4", lk_data, 20'h0000a); step("R4");

    // R3: random mix against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      idle();
      if ($urandom_range(99) < 70) begin
        look({$urandom_range(3) == 0 ? 2'($urandom_range(3)) : 2'd1, 8'($urandom_range(1)),
              10'($urandom_range(11)), 12'($urandom)}, 4'($urandom_range(3)));
        lk_ign = ($urandom_range(3) == 0) ? 5'($urandom) : 5'h0;
        large_en = 1'($urandom);
      end
      if ($urandom_range(99) < 35)
        fill({$urandom_range(3) == 0 ? 2'($urandom_range(3)) : 2'd1, 8'($urandom_range(1)),
              10'($urandom_range(11)), 12'h0},
             {($urandom_range(7) == 0) ? 1'b1 : 1'b0, 4'($urandom_range(3))}, 20'($urandom));
      if ($urandom_range(999) < 5) inv_all = 1;
      step("R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule